// File: doc/BRIEF.md
# Cascadable Presettable Up-Counter

This block is a synchronous up-counter, four bits wide by default. Two elaboration-time choices set its behaviour. The first picks the modulus: decade (0 to 9) or full binary (0 to 15). The second picks the clear: it can act at once, independent of the clock, or only at a rising edge.

- **Load.** An active-low load captures a parallel data word at the next rising edge and overrides counting.
- **Enables.** Two active-high enables, P and T, must both be high for the counter to advance.
- **Carry.** Only the T enable also gates the carry output. That output is high while T is high and the count holds its terminal value.

Wider counters are built by chaining stages. The carry of each stage feeds the T enable of the next. The P enables of all stages are tied together. The carry is purely combinational, so a wide chain resolves within one clock period without any extra pipeline stage.

Top module: `presettable_counter`

## Requirements
- R1: While `load_n` is low at a rising edge (and no clear applies), the count takes the value of `din` at that edge, whatever the enables are.
- R2: With `load_n` high, `en_p` and `en_t` both high, and the count below terminal, a rising edge adds one to the count.
- R3: With `SYNC_CLEAR` = 0, a low `clr_n` forces the count to 0 within the same cycle, before any clock edge.
- R4: With `SYNC_CLEAR` = 1, a low `clr_n` leaves the count unchanged until the next rising edge, which sets it to 0.
- R5: With `load_n` high and either `en_p` or `en_t` low, a rising edge leaves the count unchanged.
- R6: With `DECADE` = 1, an enabled count from 9, or from any loaded value 10 to 15, gives 0. Loading 7 and counting gives 8, 9, 0, 1, 2, 3.
- R7: With `DECADE` = 0, an enabled count from 15 gives 0. Loading 12 and counting gives 13, 14, 15, 0, 1, 2.
- R8: `carry` is 1 exactly when `en_t` is 1 and the count equals the terminal value (9 decade, 15 binary). It follows `en_t` without waiting for a clock edge.
- R9: Priority is clear, then load, then count: a clear at the same edge as a load gives 0, and a load at the same edge as an enabled count gives `din`.
- R10: Three decade stages chained carry-to-`en_t` count as a 3-digit decimal counter, and go from 999 to 000 in one enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, immediate or edge-timed per `SYNC_CLEAR` |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_p | input | 1 | Count enable that does not affect the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| din | input | WIDTH | Parallel load value |
| q | output | WIDTH | Current count |
| carry | output | 1 | Terminal-count flag gated by `en_t` |

## Verification
The bench steers each contested edge one of two ways: clear against load, or load against enabled counting. To do so it drives `clr_n` and `load_n` low together, or drives `load_n` low while both enables are high. It then judges which action won from the count seen a quarter period after the edge.

An immediate clear is separated from an edge-timed one by lowering `clr_n` half a period early. The count of the immediate variant is read at once; the edge-timed variant must still show its old value until the edge.

The carry is sampled right after `en_t` changes and again after the edge. This separates its combinational response from the state update.

// File: rtl/presettable_counter.sv
`timescale 1ns/1ps
module presettable_counter #(
  parameter bit DECADE     = 1'b1,
  parameter bit SYNC_CLEAR = 1'b0,
  parameter int WIDTH      = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry
);
  localparam logic [WIDTH-1:0] TERM = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_nxt;
  logic             past_term;

  assign past_term = (cnt_q >= TERM);

  always_comb begin
    if (!load_n)
      cnt_nxt = din;
    else if (en_p && en_t)
      cnt_nxt = past_term ? '0 : cnt_q + WIDTH'(1);
    else
      cnt_nxt = cnt_q;
  end

  generate
    if (SYNC_CLEAR) begin : g_sync_clr
      always_ff @(posedge clk) begin
        if (!clr_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
      end
    end else begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
      end
    end
  endgenerate

  assign q     = cnt_q;
  assign carry = en_t && (cnt_q == TERM);
endmodule

module presettable_counter_chk #(
  parameter bit DECADE     = 1'b1,
  parameter bit SYNC_CLEAR = 1'b0,
  parameter int WIDTH      = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             carry
);
  localparam logic [WIDTH-1:0] TERM = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din)); // R1
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!clr_n)
    load_n && en_p && en_t && (q < TERM) |=> q == $past(q) + WIDTH'(1)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
    load_n && !(en_p && en_t) |=> $stable(q)); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
    load_n && en_p && en_t && (q >= TERM) |=> q == '0); // R6
  AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!clr_n)
    !en_t |-> !carry); // R8
  AST_CARRY_AT_TERM: assert property (@(posedge clk) disable iff (!clr_n)
    carry |-> q == TERM); // R8

  generate
    if (SYNC_CLEAR) begin : g_sync
      AST_SYNC_CLEAR: assert property (@(posedge clk)
        !clr_n |=> q == '0); // R4
    end else begin : g_async
      AST_ASYNC_CLEAR: assert property (@(posedge clk)
        !clr_n |-> q == '0); // R3
    end
  endgenerate
endmodule

bind presettable_counter presettable_counter_chk #(
  .DECADE(DECADE), .SYNC_CLEAR(SYNC_CLEAR), .WIDTH(WIDTH)
) u_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
  .din(din), .q(q), .carry(carry)
);

// File: tb/sim_presettable_counter.sv
`timescale 1ns/1ps
module sim_presettable_counter;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       load_n = 1'b1;
  logic       en_p = 1'b0;
  logic       en_t = 1'b0;
  logic [3:0] din = '0;

  logic [3:0] q0, q1;
  logic       c0, c1;
  logic [3:0] cq [3];
  logic       cc [3];
  logic [3:0] ent;

  always #(PERIOD/2) clk = ~clk;

  presettable_counter #(.DECADE(1'b1), .SYNC_CLEAR(1'b0), .WIDTH(4)) u0 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(q0), .carry(c0));

  presettable_counter #(.DECADE(1'b0), .SYNC_CLEAR(1'b1), .WIDTH(4)) u1 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(q1), .carry(c1));

  assign ent[0] = en_t;
  generate
    for (genvar i = 0; i < 3; i++) begin : g_stage
      presettable_counter #(.DECADE(1'b1), .SYNC_CLEAR(1'b1), .WIDTH(4)) u_st (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(ent[i]),
        .din(din), .q(cq[i]), .carry(cc[i]));
      assign ent[i+1] = cc[i];
    end
  endgenerate

  typedef struct {
    int q0; bit c0; int q1; bit c1; int qc; bit cc;
  } exp_t;

  exp_t  sb[$];
  string tq[$];
  int nvec = 0, nerr = 0;
  int m0 = 0, m1 = -1;
  int cd [3] = '{0, 0, 0};
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", what, act, expv);
    end
  endtask

  function automatic int nxt(int v, bit clr, bit ld, bit p, bit t, int d, int term);
    if (!clr)       return 0;
    else if (!ld)   return d;
    else if (p && t) return (v >= term) ? 0 : v + 1;
    else            return v;
  endfunction

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  task automatic step(input bit clr, input bit ld, input bit p, input bit t,
                      input int d, input string tag);
    exp_t e;
    bit   ti [3];
    @(negedge clk);
    clr_n = clr; load_n = ld; en_p = p; en_t = t; din = 4'(d);
    if (!clr) m0 = 0;
    #1;
    chk(int'(q0) == m0, {tag, " R3 immediate count"}, int'(q0), m0);
    chk(c0 == (t && m0 == 9), {tag, " R8 carry follows en_t"}, int'(c0), int'(t && m0 == 9));
    if (m1 >= 0) chk(int'(q1) == m1, {tag, " R4 count before edge"}, int'(q1), m1);
    m0 = nxt(m0, clr, ld, p, t, d, 9);
    m1 = nxt((m1 < 0) ? 0 : m1, clr, ld, p, t, d, 15);
    ti[0] = t;
    ti[1] = t && cd[0] == 9;
    ti[2] = ti[1] && cd[1] == 9;
    for (int i = 0; i < 3; i++) cd[i] = nxt(cd[i], clr, ld, p, ti[i], d, 9);
    e.q0 = m0; e.c0 = t && m0 == 9;
    e.q1 = m1; e.c1 = t && m1 == 15;
    e.qc = cd[2] * 100 + cd[1] * 10 + cd[0];
    e.cc = t && cd[0] == 9 && cd[1] == 9 && cd[2] == 9;
    sb.push_back(e);
    tq.push_back(tag);
  endtask

  initial begin : monitor
    exp_t  e;
    string tg;
    int    qc;
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (sb.size() > 0) begin
        e  = sb.pop_front();
        tg = tq.pop_front();
        qc = int'(cq[2]) * 100 + int'(cq[1]) * 10 + int'(cq[0]);
        chk(int'(q0) == e.q0, {tg, " decade q"}, int'(q0), e.q0);
        chk(c0 == e.c0, {tg, " R8 decade carry"}, int'(c0), int'(e.c0));
        chk(int'(q1) == e.q1, {tg, " binary q"}, int'(q1), e.q1);
        chk(c1 == e.c1, {tg, " R8 binary carry"}, int'(c1), int'(e.c1));
        chk(qc == e.qc, {tg, " R10 chain value"}, qc, e.qc);
        chk(cc[2] == e.cc, {tg, " R10 chain carry"}, int'(cc[2]), int'(e.cc));
      end
    end
  end

  initial begin : watchdog
    #(PERIOD * 200000);
    nerr++;
    $display("FAIL R10 watchdog expired act=0 exp=1");
    finish_up();
  end

  initial begin : driver
    step(0, 1, 0, 0, 0, "R4 reset");
    step(0, 1, 0, 0, 0, "R3 reset");
    step(1, 0, 0, 0, 7, "R1 load seven");
    for (int i = 0; i < 6; i++) step(1, 1, 1, 1, 0, "R6 decade from seven");
    step(1, 1, 0, 1, 0, "R5 hold en_p low");
    step(1, 1, 0, 1, 0, "R5 hold en_p low");
    step(1, 1, 1, 0, 0, "R5 hold en_t low");
    step(1, 1, 1, 0, 0, "R5 hold en_t low");
    step(1, 0, 0, 0, 12, "R1 load twelve");
    for (int i = 0; i < 6; i++) step(1, 1, 1, 1, 0, "R7 binary from twelve");
    step(1, 0, 1, 1, 15, "R9 load beats count");
    step(1, 1, 1, 1, 0, "R6 fifteen to zero");
    step(1, 0, 1, 1, 11, "R9 load eleven over count");
    step(1, 1, 1, 1, 0, "R6 eleven to zero");
    step(1, 0, 0, 0, 9, "R8 load nine");
    step(1, 1, 0, 0, 0, "R8 en_t low masks carry");
    step(1, 1, 0, 1, 0, "R8 en_t high shows carry");
    step(1, 1, 1, 0, 0, "R8 en_t low again");
    step(0, 0, 1, 1, 5, "R9 clear beats load");
    for (int i = 0; i < 4; i++) step(1, 1, 1, 1, 0, "R2 plain count");
    step(0, 1, 1, 1, 0, "R3 early clear");
    step(1, 1, 1, 1, 0, "R2 count after clear");
    step(1, 0, 0, 0, 9, "R10 chain load 999");
    step(1, 1, 1, 1, 0, "R10 chain wrap");
    step(1, 0, 0, 0, 8, "R10 chain load 888");
    for (int i = 0; i < 14; i++) step(1, 1, 1, 1, 0, "R10 chain ripple");
    step(1, 1, 1, 0, 0, "R10 chain hold");
    @(negedge clk);
    @(negedge clk);
    finish_up();
  end
endmodule